// File: doc/BRIEF.md
# BISYNC Frame Transmitter

This block turns byte-oriented BISYNC messages into a synchronous serial bit stream, one bit per clock. Message bytes come in on a valid/ready stream. Each byte carries three flags: end of buffer, last buffer of the message, and append block check. A message may span several buffers. The bytes of all its buffers go out back to back, and a block check (CRC16 or an 8-bit LRC sum) is appended only at the end of a buffer that is both the last one and flagged for the check.

When no message is on the line, the transmitter fills with full SYN1–SYN2 character pairs or with all-ones idle characters. Two configuration bits choose the fill: one applies when the transmitter is enabled, the other after a frame ends. A message never starts until a complete sync pair has been sent. In transparent mode, a data byte equal to the configured DLE character goes out as a DLE pair. The pair is produced from a holding register, so no underrun gap can appear between the two characters. Outside transparent mode, the top bit of each data character can be replaced by a vertical parity bit. A reverse-data bit sends every character MSB-first. An underrun inside a frame aborts the frame: an error pulse is raised and the line sends sync characters.

Top module: `bisync_tx`

## Requirements
- R1: While `rst_n` is low, or in any cycle after `enable` was low at the previous clock edge, `txd` is 1, and `s_ready`, `buf_done` and `underrun_err` are 0.
- R2: On enable with no message pending, the line carries repeated SYN1 then SYN2 characters when `cfg_idle_sync` is 1, or all-ones (8'hFF) characters when it is 0. Sync characters are always sent as complete SYN1–SYN2 pairs.
- R3: The first data character of a message always immediately follows a complete SYN2. A byte offered during idle fill causes SYN1 and SYN2 to be sent before it.
- R4: Characters are sent LSB-first. With `cfg_reverse` set, every character (sync, DLE, data, check, idle) is sent MSB-first.
- R5: With `cfg_crc_sel` = 1, the check is CRC16 with polynomial x^16+x^15+x^2+1 and zero preset, computed LSB-first over every data character of the message as sent (all buffers). The low byte goes out first, then the high byte.
- R6: With `cfg_crc_sel` = 0, the check is one character: the sum modulo 256 of the data characters of the message as sent.
- R7: No check is appended when the final byte of a message has `s_bcs` = 0. The `s_bcs` flag is ignored at the end of a buffer whose `s_last` is 0.
- R8: After a frame ends, the next character is SYN1 if `cfg_end_sync` is 1, or 8'hFF if it is 0.
- R9: With `cfg_transparent` set, a data byte equal to `dle_char` is sent as `dle_char` followed immediately by the byte. The inserted DLE is excluded from the check, and `s_ready` stays low between the two characters.
- R10: With `cfg_parity_en` set and `cfg_transparent` clear, bit 7 of each data character is replaced by the XOR of bits 6:0 (inverted when `cfg_parity_odd` is 1). The check covers the character with this parity bit.
- R11: `buf_done` pulses for one cycle at the end of each buffer: after its last data character, or after its check characters if a check is appended.
- R12: If no byte is offered when the next data character is due within a frame, `underrun_err` pulses for one cycle, the frame is abandoned, and SYN1 then SYN2 follow.
- R13: The first byte of the next buffer of a message follows the end-of-buffer byte of the previous one directly, with no sync characters between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transmitter on; low marks the line at 1 |
| cfg_idle_sync | input | 1 | Fill after enable: 1 sync pairs, 0 idle ones |
| cfg_end_sync | input | 1 | Fill after a frame ends: 1 sync pairs, 0 idle ones |
| cfg_transparent | input | 1 | DLE doubling on, parity off |
| cfg_crc_sel | input | 1 | 1 CRC16 check, 0 LRC check |
| cfg_parity_en | input | 1 | Vertical parity in bit 7 of data characters |
| cfg_parity_odd | input | 1 | Odd parity when set |
| cfg_reverse | input | 1 | Send characters MSB-first |
| syn1_char | input | 8 | First sync character |
| syn2_char | input | 8 | Second sync character |
| dle_char | input | 8 | Escape character doubled in transparent mode |
| s_valid | input | 1 | Byte offered |
| s_ready | output | 1 | Byte taken at this clock edge when valid |
| s_data | input | 8 | Message byte |
| s_eob | input | 1 | Byte ends its buffer |
| s_last | input | 1 | Buffer is the last of the message |
| s_bcs | input | 1 | Append block check at end of buffer |
| txd | output | 1 | Serial data line |
| buf_done | output | 1 | One-cycle pulse when a buffer is finished |
| underrun_err | output | 1 | One-cycle pulse when a frame is aborted |

## Verification
The bench compares the whole serial stream of each message against characters it builds itself, including the CRC16 and LRC. A wrong polynomial, byte order or bit order therefore shows up as a mismatched check character. A design that slips a sync pair in between buffers, appends a check after a non-last buffer, or computes the check over the inserted DLE sends a stream that is too long or carries the wrong checksum. An idle-fill case catches a message that starts without its sync pair. An underrun case catches a design that keeps sending stale data instead of aborting with sync characters.

// File: rtl/bisync_tx_pkg.sv
package bisync_tx_pkg;

  // Kind of character currently on the line; one decision per character boundary.
  typedef enum logic [2:0] {
    K_OFF    = 3'd0,
    K_SYN1   = 3'd1,
    K_SYN2   = 3'd2,
    K_IDLE   = 3'd3,
    K_DLEINS = 3'd4,
    K_DATA   = 3'd5,
    K_CHK0   = 3'd6,
    K_CHK1   = 3'd7
  } char_kind_e;

endpackage

// File: rtl/bisync_char_shifter.sv
module bisync_char_shifter #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              reverse,
  input  logic [CHAR_W-1:0] char_in,
  output logic              need_char,
  output logic              txd
);

  localparam int                CNT_W    = $clog2(CHAR_W);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(CHAR_W - 1);

  logic [CHAR_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              run_q, run_d;
  logic [CHAR_W-1:0] char_rev;

  // Bit-reversed copy for MSB-first transmission.
  for (genvar gi = 0; gi < CHAR_W; gi++) begin : g_rev
    assign char_rev[gi] = char_in[CHAR_W-1-gi];
  end

  always_comb begin
    need_char = en & (~run_q | (cnt_q == LAST_BIT));
    sh_d      = sh_q;
    cnt_d     = cnt_q;
    run_d     = run_q;
    if (!en) begin
      run_d = 1'b0;
    end else if (need_char) begin
      sh_d  = reverse ? char_rev : char_in;
      cnt_d = '0;
      run_d = 1'b1;
    end else begin
      sh_d  = sh_q >> 1;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign txd = run_q ? sh_q[0] : 1'b1;

  // A started character keeps shifting until its last bit unless disabled (R4).
  assert_char_whole_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run_q && cnt_q != LAST_BIT) |=> (!en && !run_q) || (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/bisync_bcc.sv
module bisync_bcc #(
  parameter int               CHAR_W = 8,
  parameter int               CHK_W  = 16,
  parameter logic [CHK_W-1:0] POLY   = 16'hA001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic              crc_sel,
  input  logic [CHAR_W-1:0] in_char,
  output logic [CHK_W-1:0]  chk
);

  logic [CHK_W-1:0]  acc_q, acc_d;
  logic [CHK_W-1:0]  base;
  logic [CHK_W-1:0]  crc_v;
  logic [CHAR_W-1:0] lrc_v;
  logic              fb;

  always_comb begin
    base  = clr ? '0 : acc_q;
    crc_v = base;
    fb    = 1'b0;
    for (int i = 0; i < CHAR_W; i++) begin
      fb    = crc_v[0] ^ in_char[i];
      crc_v = crc_v >> 1;
      if (fb) crc_v = crc_v ^ POLY;
    end
    lrc_v = base[CHAR_W-1:0] + in_char;
    acc_d = base;
    if (upd) acc_d = crc_sel ? crc_v : {{(CHK_W-CHAR_W){1'b0}}, lrc_v};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign chk = acc_q;

  // The check value only moves when a data character is taken (R5).
  assert_chk_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !clr) |=> $stable(acc_q));

endmodule

// File: rtl/bisync_tx_ctrl.sv
module bisync_tx_ctrl
  import bisync_tx_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int CHK_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              need,
  input  logic              cfg_idle_sync,
  input  logic              cfg_end_sync,
  input  logic              cfg_transparent,
  input  logic              cfg_crc_sel,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic [CHAR_W-1:0] syn1,
  input  logic [CHAR_W-1:0] syn2,
  input  logic [CHAR_W-1:0] dle,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [CHAR_W-1:0] s_data,
  input  logic              s_eob,
  input  logic              s_last,
  input  logic              s_bcs,
  input  logic [CHK_W-1:0]  chk,
  output logic [CHAR_W-1:0] char_out,
  output logic              bcc_clr,
  output logic              bcc_upd,
  output logic [CHAR_W-1:0] bcc_char,
  output logic              buf_done,
  output logic              underrun_err
);

  char_kind_e        kind_q, kind_d;
  logic [CHAR_W-1:0] hold_q, hold_d;
  logic              hold_eob_q, hold_eob_d;
  logic              hold_last_q, hold_last_d;
  logic              hold_bcs_q, hold_bcs_d;
  logic              fill_sync_q, fill_sync_d;
  logic              bd_d, ur_d;
  logic              want, take, is_dle, par_on;
  logic [CHAR_W-1:0] fresh;
  char_kind_e        fill_kind, end_kind;

  always_comb begin
    par_on = cfg_parity_en & ~cfg_transparent;
    fresh  = s_data;
    if (par_on) fresh[CHAR_W-1] = (^s_data[CHAR_W-2:0]) ^ cfg_parity_odd;
    is_dle    = cfg_transparent & (s_data == dle);
    want      = (kind_q == K_SYN2) | ((kind_q == K_DATA) & ~(hold_eob_q & hold_last_q));
    s_ready   = need & want;
    take      = s_ready & s_valid;
    fill_kind = fill_sync_q ? K_SYN1 : K_IDLE;
    end_kind  = cfg_end_sync ? K_SYN1 : K_IDLE;
  end

  // Next-state decision, taken once per character boundary.
  always_comb begin
    kind_d      = kind_q;
    hold_d      = hold_q;
    hold_eob_d  = hold_eob_q;
    hold_last_d = hold_last_q;
    hold_bcs_d  = hold_bcs_q;
    fill_sync_d = fill_sync_q;
    bd_d        = 1'b0;
    ur_d        = 1'b0;
    bcc_clr     = 1'b0;
    bcc_upd     = 1'b0;
    if (!en) begin
      kind_d = K_OFF;
    end else if (need) begin
      unique case (kind_q)
        K_OFF: begin
          kind_d      = (s_valid | cfg_idle_sync) ? K_SYN1 : K_IDLE;
          fill_sync_d = cfg_idle_sync;
        end
        K_SYN1:   kind_d = K_SYN2;
        K_SYN2:   if (!take) kind_d = fill_kind;
        K_IDLE:   kind_d = s_valid ? K_SYN1 : fill_kind;
        K_DLEINS: kind_d = K_DATA;
        K_DATA: begin
          if (hold_eob_q & hold_last_q) begin
            if (hold_bcs_q) begin
              kind_d = K_CHK0;
            end else begin
              kind_d      = end_kind;
              fill_sync_d = cfg_end_sync;
              bd_d        = 1'b1;
            end
          end else begin
            bd_d = hold_eob_q;
            if (!take) begin
              kind_d      = K_SYN1;
              fill_sync_d = 1'b1;
              ur_d        = 1'b1;
            end
          end
        end
        K_CHK0: begin
          if (cfg_crc_sel) begin
            kind_d = K_CHK1;
          end else begin
            kind_d      = end_kind;
            fill_sync_d = cfg_end_sync;
            bd_d        = 1'b1;
          end
        end
        K_CHK1: begin
          kind_d      = end_kind;
          fill_sync_d = cfg_end_sync;
          bd_d        = 1'b1;
        end
        default: kind_d = K_OFF;
      endcase
      if (take) begin
        kind_d      = is_dle ? K_DLEINS : K_DATA;
        hold_d      = fresh;
        hold_eob_d  = s_eob;
        hold_last_d = s_last;
        hold_bcs_d  = s_bcs;
        bcc_upd     = 1'b1;
        bcc_clr     = (kind_q == K_SYN2);
      end
    end
  end

  assign bcc_char = fresh;

  always_comb begin
    unique case (kind_d)
      K_SYN1:   char_out = syn1;
      K_SYN2:   char_out = syn2;
      K_DLEINS: char_out = dle;
      K_DATA:   char_out = hold_d;
      K_CHK0:   char_out = chk[CHAR_W-1:0];
      K_CHK1:   char_out = chk[CHAR_W +: CHAR_W];
      default:  char_out = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q       <= K_OFF;
      hold_q       <= '0;
      hold_eob_q   <= 1'b0;
      hold_last_q  <= 1'b0;
      hold_bcs_q   <= 1'b0;
      fill_sync_q  <= 1'b0;
      buf_done     <= 1'b0;
      underrun_err <= 1'b0;
    end else begin
      kind_q       <= kind_d;
      hold_q       <= hold_d;
      hold_eob_q   <= hold_eob_d;
      hold_last_q  <= hold_last_d;
      hold_bcs_q   <= hold_bcs_d;
      fill_sync_q  <= fill_sync_d;
      buf_done     <= bd_d;
      underrun_err <= ur_d;
    end
  end

  // A message opens only right after SYN2 (R3).
  assert_pair_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind_q != K_DATA) |-> kind_q == K_SYN2);

  // SYN1 is always followed by SYN2 (R2).
  assert_syn_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && need && kind_q == K_SYN1) |=> kind_q == K_SYN2);

  // No byte is taken between an inserted DLE and its partner (R9).
  assert_dle_no_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_DLEINS) |-> !s_ready);

  // Check characters follow only a last buffer flagged for them (R7).
  assert_check_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && need && kind_q == K_DATA && !(hold_eob_q && hold_last_q && hold_bcs_q))
      |=> kind_q != K_CHK0);

  // An abort puts SYN1 on the line (R12).
  assert_underrun_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_err |-> kind_q == K_SYN1);

  // Buffer completion is a single-cycle pulse (R11).
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |=> !buf_done);

endmodule

// File: rtl/bisync_tx.sv
module bisync_tx #(
  parameter int                 CHAR_W   = 8,
  parameter int                 CHK_W    = 16,
  parameter logic [CHK_W-1:0]   CRC_POLY = 16'hA001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_idle_sync,
  input  logic              cfg_end_sync,
  input  logic              cfg_transparent,
  input  logic              cfg_crc_sel,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              cfg_reverse,
  input  logic [CHAR_W-1:0] syn1_char,
  input  logic [CHAR_W-1:0] syn2_char,
  input  logic [CHAR_W-1:0] dle_char,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [CHAR_W-1:0] s_data,
  input  logic              s_eob,
  input  logic              s_last,
  input  logic              s_bcs,
  output logic              txd,
  output logic              buf_done,
  output logic              underrun_err
);

  logic              need;
  logic [CHAR_W-1:0] char_next;
  logic              bcc_clr, bcc_upd;
  logic [CHAR_W-1:0] bcc_char;
  logic [CHK_W-1:0]  chk;

  bisync_char_shifter #(.CHAR_W(CHAR_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (enable),
    .reverse   (cfg_reverse),
    .char_in   (char_next),
    .need_char (need),
    .txd       (txd)
  );

  bisync_bcc #(.CHAR_W(CHAR_W), .CHK_W(CHK_W), .POLY(CRC_POLY)) u_bcc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (bcc_clr),
    .upd     (bcc_upd),
    .crc_sel (cfg_crc_sel),
    .in_char (bcc_char),
    .chk     (chk)
  );

  bisync_tx_ctrl #(.CHAR_W(CHAR_W), .CHK_W(CHK_W)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .en              (enable),
    .need            (need),
    .cfg_idle_sync   (cfg_idle_sync),
    .cfg_end_sync    (cfg_end_sync),
    .cfg_transparent (cfg_transparent),
    .cfg_crc_sel     (cfg_crc_sel),
    .cfg_parity_en   (cfg_parity_en),
    .cfg_parity_odd  (cfg_parity_odd),
    .syn1            (syn1_char),
    .syn2            (syn2_char),
    .dle             (dle_char),
    .s_valid         (s_valid),
    .s_ready         (s_ready),
    .s_data          (s_data),
    .s_eob           (s_eob),
    .s_last          (s_last),
    .s_bcs           (s_bcs),
    .chk             (chk),
    .char_out        (char_next),
    .bcc_clr         (bcc_clr),
    .bcc_upd         (bcc_upd),
    .bcc_char        (bcc_char),
    .buf_done        (buf_done),
    .underrun_err    (underrun_err)
  );

  // A disabled transmitter marks the line and takes nothing (R1).
  assert_line_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (txd && !s_ready && !underrun_err));

endmodule

// File: tb/bisync_tx_bench.sv
module bisync_tx_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] SYN1 = 8'h16;
  localparam logic [7:0] SYN2 = 8'h26;
  localparam logic [7:0] DLE  = 8'h10;

  typedef struct packed {
    logic [23:0] tag;
    logic [2:0]  n;
    logic [31:0] bytes;
    logic        bcs;
    logic        crc;
    logic        trans;
    logic        par;
    logic        odd;
    logic        rev;
    logic        end_sync;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{"R5 ", 3'd3, 32'h00434241, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{"R6 ", 3'd3, 32'h00434241, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R9 ", 3'd2, 32'h00004110, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{"R10", 3'd2, 32'h00004143, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{"R10", 3'd1, 32'h00000041, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    '{"R4 ", 3'd2, 32'h00008001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{"R7 ", 3'd2, 32'h0000AA55, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R9 ", 3'd3, 32'h00021010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{"R8 ", 3'd1, 32'h0000007E, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic enable;
  logic cfg_idle_sync, cfg_end_sync, cfg_transparent, cfg_crc_sel;
  logic cfg_parity_en, cfg_parity_odd, cfg_reverse;
  logic s_valid, s_ready, s_eob, s_last, s_bcs;
  logic [7:0] s_data;
  logic txd, buf_done, underrun_err;

  int n_chk  = 0;
  int n_fail = 0;
  int bd_cnt = 0;
  int ur_cnt = 0;

  logic [10:0] drv_q[$];
  logic        pend = 1'b0;
  logic [7:0]  exp_q[$];
  logic [7:0]  dat_q[$];
  logic        pb_ok = 1'b0;
  logic        pb_bit = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bisync_tx u_bisync_tx (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_idle_sync(cfg_idle_sync), .cfg_end_sync(cfg_end_sync),
    .cfg_transparent(cfg_transparent), .cfg_crc_sel(cfg_crc_sel),
    .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
    .cfg_reverse(cfg_reverse),
    .syn1_char(SYN1), .syn2_char(SYN2), .dle_char(DLE),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_eob(s_eob), .s_last(s_last), .s_bcs(s_bcs),
    .txd(txd), .buf_done(buf_done), .underrun_err(underrun_err)
  );

  // Stream driver: presents the queue head, pops after a handshake.
  always @(negedge clk) begin
    if (pend && drv_q.size() > 0) void'(drv_q.pop_front());
    if (drv_q.size() > 0) begin
      s_valid = 1'b1;
      {s_bcs, s_last, s_eob, s_data} = drv_q[0];
    end else begin
      s_valid = 1'b0;
    end
    #1;
    pend = s_valid & s_ready;
  end

  always @(negedge clk) begin
    if (buf_done) bd_cnt++;
    if (underrun_err) ur_cnt++;
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  task automatic check(input string tag, input logic ok, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic get_bit(output logic b);
    if (pb_ok) begin
      b = pb_bit;
      pb_ok = 1'b0;
    end else begin
      @(negedge clk);
      b = txd;
    end
  endtask

  task automatic expect_chars(input string tag, input logic rev);
    foreach (exp_q[i]) begin
      logic [7:0] r;
      r = 8'h00;
      for (int k = 0; k < 8; k++) begin
        logic bt;
        get_bit(bt);
        if (rev) r[7-k] = bt;
        else     r[k]   = bt;
      end
      check(tag, r == exp_q[i], {8'h00, r}, {8'h00, exp_q[i]});
    end
  endtask

  function automatic logic [15:0] crc_ref();
    logic [15:0] c;
    c = 16'h0000;
    foreach (dat_q[i]) begin
      logic [7:0] rb;
      rb = {<<{dat_q[i]}};
      c = c ^ {rb, 8'h00};
      for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
    end
    return {<<{c}};
  endfunction

  function automatic logic [7:0] lrc_ref();
    logic [7:0] s;
    s = 8'h00;
    foreach (dat_q[i]) s = s + dat_q[i];
    return s;
  endfunction

  task automatic add_data(input logic [7:0] b, input logic trans, input logic par, input logic odd);
    logic [7:0] pb;
    pb = b;
    if (par && !trans) pb[7] = ($countones(b[6:0]) % 2 == 1) ^ odd;
    if (trans && b == DLE) exp_q.push_back(DLE);
    exp_q.push_back(pb);
    dat_q.push_back(pb);
  endtask

  task automatic add_check(input logic bcs, input logic crc);
    logic [15:0] c;
    if (bcs) begin
      if (crc) begin
        c = crc_ref();
        exp_q.push_back(c[7:0]);
        exp_q.push_back(c[15:8]);
      end else begin
        exp_q.push_back(lrc_ref());
      end
    end
  endtask

  task automatic set_cfg(input logic idle_s, input logic end_s, input logic trans, input logic crc,
                         input logic par, input logic odd, input logic rev);
    cfg_idle_sync = idle_s; cfg_end_sync = end_s; cfg_transparent = trans; cfg_crc_sel = crc;
    cfg_parity_en = par; cfg_parity_odd = odd; cfg_reverse = rev;
  endtask

  task automatic stop_tx(input logic chk_idle);
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    if (chk_idle) begin
      check("R1", txd === 1'b1, {15'd0, txd}, 16'd1);
      check("R1", s_ready === 1'b0, {15'd0, s_ready}, 16'd0);
    end
    drv_q.delete();
    exp_q.delete();
    dat_q.delete();
    pb_ok = 1'b0;
    bd_cnt = 0;
    ur_cnt = 0;
    @(negedge clk);
  endtask

  task automatic go();
    @(negedge clk);
    @(negedge clk);
    enable = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    enable = 1'b0;
    s_valid = 1'b0; s_data = 8'h00; s_eob = 1'b0; s_last = 1'b0; s_bcs = 1'b0;
    set_cfg(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R1", txd === 1'b1, {15'd0, txd}, 16'd1);
    check("R1", s_ready === 1'b0, {15'd0, s_ready}, 16'd0);
    check("R1", buf_done === 1'b0 && underrun_err === 1'b0, {14'd0, buf_done, underrun_err}, 16'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Vector table: single-buffer messages under varied settings.
    foreach (VECS[vi]) begin
      vec_t v;
      string tg;
      v = VECS[vi];
      tg = $sformatf("%s", v.tag);
      set_cfg(1'b1, v.end_sync, v.trans, v.crc, v.par, v.odd, v.rev);
      exp_q.push_back(SYN1);
      exp_q.push_back(SYN2);
      for (int i = 0; i < int'(v.n); i++) begin
        logic [7:0] b;
        logic       fin;
        b = v.bytes[8*i +: 8];
        fin = (i == int'(v.n) - 1);
        drv_q.push_back({v.bcs, fin, fin, b});
        add_data(b, v.trans, v.par, v.odd);
      end
      add_check(v.bcs, v.crc);
      exp_q.push_back(v.end_sync ? SYN1 : 8'hFF);
      go();
      expect_chars(tg, v.rev);
      check("R11", bd_cnt == 1, 16'(bd_cnt), 16'd1);
      stop_tx(1'b1);
    end

    // Sync-pair fill with nothing to send (R2).
    set_cfg(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    exp_q.push_back(SYN1); exp_q.push_back(SYN2);
    exp_q.push_back(SYN1); exp_q.push_back(SYN2);
    go();
    expect_chars("R2", 1'b0);
    stop_tx(1'b0);

    // Idle fill, then a message: sync pair must precede data (R2, R3).
    set_cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    go();
    begin
      logic ones;
      ones = 1'b1;
      for (int k = 0; k < 16; k++) begin
        logic bt;
        get_bit(bt);
        ones = ones & bt;
      end
      check("R2", ones, {15'd0, ones}, 16'd1);
    end
    drv_q.push_back({1'b1, 1'b1, 1'b1, 8'h41});
    exp_q.push_back(SYN1); exp_q.push_back(SYN2);
    add_data(8'h41, 1'b0, 1'b0, 1'b0);
    add_check(1'b1, 1'b0);
    exp_q.push_back(SYN1);
    begin
      logic found;
      found = 1'b0;
      for (int k = 0; k < 40 && !found; k++) begin
        @(negedge clk);
        if (txd == 1'b0) found = 1'b1;
      end
      check("R3", found, {15'd0, found}, 16'd1);
      pb_ok = 1'b1;
      pb_bit = 1'b0;
    end
    expect_chars("R3", 1'b0);
    stop_tx(1'b0);

    // Multi-buffer message: check flag ignored on non-last buffer (R7, R13, R11).
    set_cfg(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    drv_q.push_back({1'b1, 1'b0, 1'b1, 8'h31});
    drv_q.push_back({1'b0, 1'b0, 1'b0, 8'h32});
    drv_q.push_back({1'b1, 1'b1, 1'b1, 8'h33});
    exp_q.push_back(SYN1); exp_q.push_back(SYN2);
    add_data(8'h31, 1'b0, 1'b0, 1'b0);
    add_data(8'h32, 1'b0, 1'b0, 1'b0);
    add_data(8'h33, 1'b0, 1'b0, 1'b0);
    add_check(1'b1, 1'b1);
    exp_q.push_back(SYN1);
    go();
    expect_chars("R13", 1'b0);
    check("R11", bd_cnt == 2, 16'(bd_cnt), 16'd2);
    stop_tx(1'b0);

    // Underrun after a non-last buffer aborts with sync characters (R12).
    set_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    drv_q.push_back({1'b0, 1'b0, 1'b0, 8'h51});
    drv_q.push_back({1'b1, 1'b0, 1'b1, 8'h52});
    exp_q.push_back(SYN1); exp_q.push_back(SYN2);
    exp_q.push_back(8'h51); exp_q.push_back(8'h52);
    exp_q.push_back(SYN1); exp_q.push_back(SYN2);
    exp_q.push_back(SYN1);
    go();
    expect_chars("R12", 1'b0);
    check("R12", ur_cnt == 1, 16'(ur_cnt), 16'd1);
    stop_tx(1'b1);

    summary();
    $finish;
  end

endmodule